// File: doc/BRIEF.md
# Four-Way Byte-Interleaved Memory

This block is a 4 KB byte-addressable store built from four byte-wide banks of 1 KB each. Consecutive byte addresses fall in consecutive banks, so an aligned 32-bit word sits at the same index in all four banks and moves in one bank access instead of four. A requester presents an address, a read/write control and exactly one of three size strobes (byte, halfword, word). The block decodes a per-bank enable from the size and the two low address bits, drives every bank with the shared index taken from address bits [11:2], and moves data on the byte lane that belongs to each bank.

Requests use a valid/ready handshake. `req_ready` is always high, so a request is taken on every clock edge where `req_valid` is high and there is no back-pressure. Responses carry `rsp_valid` and have no ready: the consumer must accept a response in the cycle it appears, one clock after its request. Addresses with any bit above bit 11 set enable no bank. A request whose address is misaligned for its size, or that raises more than one size strobe, enables no bank and reports an error with its response. Byte reordering inside the requester is out of scope.

Top module: `interleaved_mem`

## Requirements
- R1: A byte request (only `req_byte` high) in the window enables exactly the bank numbered by `req_addr[1:0]`; a read returns the byte at index `req_addr[11:2]` of that bank on lane n = `req_addr[1:0]` (bits [8n+7:8n]).
- R2: A halfword request at an even address enables banks 0 and 1 when `req_addr[1]` is 0, banks 2 and 3 when it is 1, both at index `req_addr[11:2]`.
- R3: A word request at an address with `req_addr[1:0]` = 0 enables all four banks at index `req_addr[11:2]` and moves all 32 bits in one request.
- R4: If any of `req_addr[31:12]` is nonzero, `bank_en` is 0, no bank is written and read data is 0; the window check alone raises no error.
- R5: A halfword request at an odd address, or a word request with `req_addr[1:0]` nonzero, enables no bank and its response carries `rsp_err` = 1.
- R6: With no size strobe high, no bank is enabled and `rsp_err` is 0; with two or more strobes high, no bank is enabled and `rsp_err` is 1.
- R7: A write (`req_read` = 0) stores lane n of `req_wdata` only into enabled bank n; bytes in disabled banks keep their value.
- R8: Read data (`req_read` = 1) appears on `rsp_data` in the cycle after the request; lanes of banks not enabled for a read, and all lanes after a write or idle cycle, are 0.
- R9: `req_ready` is always 1; `rsp_valid` is high exactly in the cycle after each cycle with `req_valid` high; `bank_en` is 0 whenever `req_valid` is 0.
- R10: While and right after reset, `rsp_valid`, `rsp_err` and `rsp_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_addr | input | 32 | Byte address |
| req_read | input | 1 | 1 = read, 0 = write |
| req_byte | input | 1 | Byte size strobe |
| req_half | input | 1 | Halfword size strobe |
| req_word | input | 1 | Word size strobe |
| req_wdata | input | 32 | Write data, lane n feeds bank n |
| bank_en | output | 4 | Per-bank enable for the current request |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 32 | Read data, lane n from bank n |
| rsp_err | output | 1 | Misaligned or conflicting-size request |

## Verification
`bank_en` is combinational on the request, so it is due in the same cycle and the bench reads it a moment after driving inputs on the falling edge. `rsp_valid`, `rsp_err` and `rsp_data` pass through one register stage and are due one clock later; the bench samples them at the next falling edge, before the next request is driven. A byte-level model in the bench tracks every write, so reads after full-memory sweeps, partial writes and rejected writes are all compared against computed contents.

// File: rtl/imem_pkg.sv
package imem_pkg;
  localparam int LANES  = 4;
  localparam int SEL_W  = 2;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    SZ_NONE,
    SZ_BYTE,
    SZ_HALF,
    SZ_WORD,
    SZ_MULTI
  } size_e;
endpackage

// File: rtl/imem_decode.sv
module imem_decode
  import imem_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sz_b,
  input  logic              sz_h,
  input  logic              sz_w,
  output logic [LANES-1:0]  en,
  output logic              err,
  output logic [IDX_W-1:0]  idx
);
  localparam int WIN_W = SEL_W + IDX_W;

  size_e            size;
  logic [SEL_W-1:0] lo;
  logic             in_win;
  logic             misalign;
  logic [LANES-1:0] lane_hit;

  assign lo     = addr[SEL_W-1:0];
  assign idx    = addr[WIN_W-1:SEL_W];
  assign in_win = ~|addr[ADDR_W-1:WIN_W];

  always_comb begin
    unique case ({sz_w, sz_h, sz_b})
      3'b000:  size = SZ_NONE;
      3'b001:  size = SZ_BYTE;
      3'b010:  size = SZ_HALF;
      3'b100:  size = SZ_WORD;
      default: size = SZ_MULTI;
    endcase
  end

  assign misalign = ((size == SZ_HALF) && lo[0]) ||
                    ((size == SZ_WORD) && (lo != '0));

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    localparam logic [SEL_W-1:0] BSEL = SEL_W'(b);
    always_comb begin
      unique case (size)
        SZ_BYTE: lane_hit[b] = (lo == BSEL);
        SZ_HALF: lane_hit[b] = (lo[1] == BSEL[1]);
        SZ_WORD: lane_hit[b] = 1'b1;
        default: lane_hit[b] = 1'b0;
      endcase
    end
  end

  assign en  = (valid && in_win && !misalign) ? lane_hit : '0;
  assign err = valid && (misalign || (size == SZ_MULTI));
endmodule

// File: rtl/imem_bank.sv
module imem_bank
  import imem_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rd,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wd,
  output logic [BYTE_W-1:0] rq
);
  localparam int DEPTH = 2 ** IDX_W;

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && !rd) mem[idx] <= wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rq <= '0;
    else if (en && rd)  rq <= mem[idx];
    else                rq <= '0;
  end
endmodule

// File: rtl/interleaved_mem.sv
module interleaved_mem
  import imem_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    req_read,
  input  logic                    req_byte,
  input  logic                    req_half,
  input  logic                    req_word,
  input  logic [LANES*BYTE_W-1:0] req_wdata,
  output logic [LANES-1:0]        bank_en,
  output logic                    rsp_valid,
  output logic [LANES*BYTE_W-1:0] rsp_data,
  output logic                    rsp_err
);
  localparam int WIN_W = SEL_W + IDX_W;

  logic             dec_err;
  logic [IDX_W-1:0] idx;

  assign req_ready = 1'b1;

  imem_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .valid (req_valid),
    .addr  (req_addr),
    .sz_b  (req_byte),
    .sz_h  (req_half),
    .sz_w  (req_word),
    .en    (bank_en),
    .err   (dec_err),
    .idx   (idx)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    imem_bank #(.IDX_W(IDX_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (bank_en[b]),
      .rd    (req_read),
      .idx   (idx),
      .wd    (req_wdata[b*BYTE_W +: BYTE_W]),
      .rq    (rsp_data[b*BYTE_W +: BYTE_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= dec_err;
    end
  end

  // R4: outside the window nothing is enabled
  a_r4_window_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_addr[ADDR_W-1:WIN_W] != '0)) |-> (bank_en == '0));

  // R5: misaligned word or halfword enables nothing and reports an error
  a_r5_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ((req_word && !req_half && !req_byte && (req_addr[1:0] != 2'b00)) ||
                   (req_half && !req_word && !req_byte && req_addr[0])))
    |-> ((bank_en == '0) ##1 rsp_err));

  // R3: aligned in-window word enables every bank
  a_r3_word_all: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_word && !req_half && !req_byte && (req_addr[1:0] == 2'b00) &&
     (req_addr[ADDR_W-1:WIN_W] == '0)) |-> (bank_en == '1));

  // R1: a byte request never enables more than one bank
  a_r1_byte_single: assert property (@(posedge clk) disable iff (!rst_n)
    (req_byte && !req_half && !req_word) |-> $onehot0(bank_en));

  // R9: one response per accepted request, no enables when idle
  a_r9_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> ((bank_en == '0) ##1 !rsp_valid));

  // R8: after a write or idle cycle all read lanes are zero
  a_r8_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || !req_read) |=> (rsp_data == '0));
endmodule

// File: tb/interleaved_mem_test.sv
`timescale 1ns/1ps
module interleaved_mem_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_read = 1'b1;
  logic        req_byte = 1'b0;
  logic        req_half = 1'b0;
  logic        req_word = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  bank_en;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_err;

  int checks = 0;
  int failures = 0;
  logic [7:0] model [4096];

  always #10 clk = ~clk;

  interleaved_mem uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_read(req_read), .req_byte(req_byte),
    .req_half(req_half), .req_word(req_word), .req_wdata(req_wdata),
    .bank_en(bank_en), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // sz = {word, half, byte}
  task automatic do_req(input logic [31:0] a, input logic rd, input logic [2:0] sz,
                        input logic [31:0] wd, input string tag);
    logic [3:0]  e_en;
    logic        e_err;
    logic [31:0] e_d;
    logic        mis;
    logic        multi;
    mis   = (sz == 3'b010 && a[0]) || (sz == 3'b100 && a[1:0] != 2'b00);
    multi = (sz[0] + sz[1] + sz[2]) > 1;
    e_err = mis || multi;
    e_en  = 4'h0;
    if ((a >> 12) == 0 && !e_err) begin
      case (sz)
        3'b001: e_en = 4'h1 << a[1:0];
        3'b010: e_en = 4'h3 << a[1:0];
        3'b100: e_en = 4'hF;
        default: e_en = 4'h0;
      endcase
    end
    e_d = '0;
    for (int l = 0; l < 4; l++)
      if (e_en[l] && rd) e_d[8*l +: 8] = model[(a[11:2] * 4) + l];
    req_valid = 1'b1; req_addr = a; req_read = rd;
    {req_word, req_half, req_byte} = sz; req_wdata = wd;
    #1;
    check(tag, "bank_en", {28'd0, bank_en}, {28'd0, e_en});
    check("R9", "req_ready", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    check("R9", "rsp_valid", {31'd0, rsp_valid}, 32'd1);
    check(tag, "rsp_err", {31'd0, rsp_err}, {31'd0, e_err});
    check(tag, "rsp_data", rsp_data, e_d);
    if (!rd)
      for (int l = 0; l < 4; l++)
        if (e_en[l]) model[(a[11:2] * 4) + l] = wd[8*l +: 8];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    check("R10", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R10", "rsp_err", {31'd0, rsp_err}, 32'd0);
    check("R10", "rsp_data", rsp_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "rsp_valid after release", {31'd0, rsp_valid}, 32'd0);

    // R3/R7: fill all memory with aligned word writes
    for (int i = 0; i < 1024; i++)
      do_req(i * 4, 1'b0, 3'b100, (i * 32'h0001_0203) ^ 32'hA5C3_3C5A, "R3");
    // R1/R8: every byte address
    for (int a = 0; a < 4096; a++) do_req(a, 1'b1, 3'b001, '0, "R1");
    // R2/R5: every halfword address (odd ones rejected)
    for (int a = 0; a < 4096; a++) do_req(a, 1'b1, 3'b010, '0, a[0] ? "R5" : "R2");
    // R3/R5: every word address (unaligned rejected)
    for (int a = 0; a < 4096; a++) do_req(a, 1'b1, 3'b100, '0, (a % 4) != 0 ? "R5" : "R3");
    // R7: partial writes followed by a full word read
    for (int a = 0; a < 512; a++) begin
      do_req(a * 7 % 4096, 1'b0, 3'b001, 32'h1111_1111 * (a % 15), "R7");
      do_req((a * 7 % 4096) & ~32'd3, 1'b1, 3'b100, '0, "R7");
      do_req((a * 11 % 4096) & ~32'd1, 1'b0, 3'b010, ~(32'h0101_0101 * a), "R7");
      do_req((a * 11 % 4096) & ~32'd3, 1'b1, 3'b100, '0, "R7");
    end
    // R5: misaligned writes must not touch memory
    for (int a = 0; a < 64; a++) begin
      do_req(a * 4 + 1 + (a % 3), 1'b0, 3'b100, 32'hDEAD_BEEF, "R5");
      do_req(a * 4 + 1, 1'b0, 3'b010, 32'hCAFE_F00D, "R5");
      do_req(a * 4, 1'b1, 3'b100, '0, "R5");
    end
    // R4: out-of-window reads and writes, then check aliases unchanged
    for (int k = 12; k < 32; k++) begin
      do_req((32'd1 << k) | (k * 4), 1'b0, 3'b100, 32'h0BAD_0BAD, "R4");
      do_req((32'd1 << k) | (k * 4), 1'b1, 3'b100, '0, "R4");
      do_req((32'd1 << k) | (k + 1), 1'b1, 3'b001, '0, "R4");
      do_req(k * 4, 1'b1, 3'b100, '0, "R4");
    end
    // R6: every strobe combination, read and write
    for (int s = 0; s < 8; s++) begin
      do_req(32'h40, 1'b0, 3'(s), 32'h7654_3210 + s, "R6");
      do_req(32'h40, 1'b1, 3'(s), '0, "R6");
      do_req(32'h40, 1'b1, 3'b100, '0, "R6");
    end
    // R9/R8: idle cycles
    req_valid = 1'b0; req_read = 1'b1; req_word = 1'b1; req_addr = 32'h0;
    #1;
    check("R9", "bank_en idle", {28'd0, bank_en}, 32'd0);
    @(negedge clk);
    check("R9", "rsp_valid idle", {31'd0, rsp_valid}, 32'd0);
    check("R8", "rsp_data idle", rsp_data, 32'd0);
    check("R9", "rsp_err idle", {31'd0, rsp_err}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule